// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Port

This block is a full-duplex asynchronous serial transmitter and receiver that supports three framing arrangements, chosen by a two-bit mode input. The short frame carries 8 data bits between a low start bit and a high stop bit. The two long frames insert a ninth data bit, set by software, just before the stop bit. The two long modes differ only in where their bit timing comes from. One derives it from the block clock at a fixed fraction. The other uses an externally supplied oversampling tick, which the short frame also uses.

Software writes a byte and a ninth bit through a one-cycle write strobe. It reads back the last received byte and a received ninth bit. It sees sticky transmit-done, receive-done and framing-error flags, each cleared by its own pulse. A single control-readback bit shows either the framing error or mode bit 0, depending on a visibility input. The receiver oversamples every bit sixteen times. It decides each bit by a two-of-three vote around the bit centre and drops a start bit that turns out to be noise.

Top module: `mm_serial_port`

## Requirements
- R1: A write while the transmitter is idle sends, on `txd`, a low start bit, then the 8 data bits with bit 0 first, then a high stop bit. Each bit lasts 16 oversampling ticks, and `txd` rests high between frames.
- R2: In the short frame (`frame_mode` 2'b00 or 2'b01), the receiver stores the 8 data bits in `rx_data` and the sampled stop-bit value in `rx_bit9`.
- R3: In the long frames (`frame_mode[1]`=1), the value of `tx_bit9` given with the write is sent as one extra bit between data bit 7 and the stop bit.
- R4: In the long frames, the received ninth bit is stored in `rx_bit9`, and the stop-bit value is not kept there.
- R5: Mode 2'b10 times bits from the clock: 16 clocks per bit when `fix_slow`=0, and 32 clocks per bit when `fix_slow`=1. In that mode `var_tick` is ignored. All other modes count `var_tick` pulses, 16 per bit.
- R6: A stop bit sampled low sets `fe_flag`. The flag stays set through later good frames until a `clr_fe` pulse clears it.
- R7: `ctrl_top` equals `fe_flag` when `fe_vis`=1, and equals `frame_mode[0]` when `fe_vis`=0.
- R8: Each received bit takes the majority of oversampling samples 7, 8 and 9 of its 16. A disturbance that reaches only one of those samples does not change the bit.
- R9: If the vote at the centre of the start bit is high, the receiver returns to idle without raising `rx_done`. It then accepts the next real frame.
- R10: `tx_done` rises when the stop bit has been fully sent, and `rx_done` rises at the centre of the received stop bit. Each stays set until its own clear pulse.
- R11: A write while a frame is being sent is ignored. The frame in flight is unchanged and no further frame follows.
- R12: After reset, `txd` is high, all three flags are low and `rx_data`/`rx_bit9` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_mode | input | 2 | 00/01 short frame on var_tick, 10 long frame on clock, 11 long frame on var_tick |
| fix_slow | input | 1 | In mode 10: 0 gives 16 clocks per bit, 1 gives 32 |
| fe_vis | input | 1 | Selects what ctrl_top shows |
| var_tick | input | 1 | Oversampling tick (16 per bit) for the variable-rate modes |
| tx_wr | input | 1 | Write strobe for transmit data |
| tx_data | input | 8 | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send in long frames |
| clr_tx_done | input | 1 | Clears tx_done |
| clr_rx_done | input | 1 | Clears rx_done |
| clr_fe | input | 1 | Clears fe_flag |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_data | output | 8 | Last received byte |
| rx_bit9 | output | 1 | Received ninth bit, or stop bit in short frames |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| fe_flag | output | 1 | Framing-error status flag |
| ctrl_top | output | 1 | Control readback bit: framing error or mode bit 0 |

## Verification
The bench uses the default parameters: 8 data bits and 16 samples per bit. In mode 10 with `fix_slow`=0 this makes a bit exactly 16 clocks long, one sample per clock. The bench can therefore place a one-clock disturbance on exactly one voting sample, or release a false start before the centre vote. The variable-rate modes are driven with a tick on every third clock, giving 48-clock bits that are clearly separate from the 16- and 32-clock fixed rates. Most frames loop `txd` back into `rxd`, so one frame checks both the transmit bit order and the receiver's storage of the ninth and stop bits.

// File: rtl/mm_serial_pkg.sv
package mm_serial_pkg;

  typedef enum logic [1:0] {
    FM_SHORT_A = 2'b00,
    FM_SHORT   = 2'b01,
    FM_LONG_FX = 2'b10,
    FM_LONG_VR = 2'b11
  } frame_mode_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic is_long(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/mm_serial_tick.sv
module mm_serial_tick
  import mm_serial_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] frame_mode,
  input  logic       fix_slow,
  input  logic       var_tick,
  output logic       tick
);

  logic ph_q, ph_d;
  logic fixed_src;

  always_comb begin
    ph_d      = ~ph_q;
    fixed_src = (frame_mode == FM_LONG_FX);
    tick      = fixed_src ? (fix_slow ? ph_q : 1'b1) : var_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  // R5: the halved clock rate never gives two ticks in a row
  a_r5_slow_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_src && fix_slow && tick) |=>
      (!tick || !$stable(frame_mode) || !$stable(fix_slow)));

endmodule

// File: rtl/mm_serial_tx.sv
module mm_serial_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          long_frame,
  input  logic          wr,
  input  logic [DW-1:0] data,
  input  logic          bit9,
  input  logic          clr_done,
  output logic          txd,
  output logic          done
);

  localparam int CW = $clog2(OVS);
  localparam int FW = DW + 3;
  localparam int BW = $clog2(FW);
  localparam logic [CW-1:0] TC_END = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_S = BW'(DW + 1);
  localparam logic [BW-1:0] LAST_L = BW'(DW + 2);

  logic          busy_q, busy_d;
  logic          f11_q, f11_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] tc_q, tc_d;
  logic [BW-1:0] bc_q, bc_d;
  logic          done_q, done_d;
  logic          done_set;
  logic [BW-1:0] last_idx;

  always_comb begin
    busy_d   = busy_q;
    f11_d    = f11_q;
    sh_d     = sh_q;
    tc_d     = tc_q;
    bc_d     = bc_q;
    done_set = 1'b0;
    last_idx = f11_q ? LAST_L : LAST_S;
    if (!busy_q) begin
      if (wr) begin
        busy_d = 1'b1;
        f11_d  = long_frame;
        sh_d   = {1'b1, (long_frame ? bit9 : 1'b1), data, 1'b0};
        tc_d   = '0;
        bc_d   = '0;
      end
    end else if (tick) begin
      if (tc_q == TC_END) begin
        tc_d = '0;
        sh_d = {1'b1, sh_q[FW-1:1]};
        if (bc_q == last_idx) begin
          busy_d   = 1'b0;
          done_set = 1'b1;
        end else begin
          bc_d = bc_q + 1'b1;
        end
      end else begin
        tc_d = tc_q + 1'b1;
      end
    end
    done_d = done_set ? 1'b1 : (clr_done ? 1'b0 : done_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      f11_q  <= 1'b0;
      sh_q   <= '1;
      tc_q   <= '0;
      bc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      f11_q  <= f11_d;
      sh_q   <= sh_d;
      tc_q   <= tc_d;
      bc_q   <= bc_d;
      done_q <= done_d;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign done = done_q;

  // R1: every frame opens with a low start bit
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd);

  // R11: a write during a frame leaves the frame untouched
  a_r11_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr && !tick) |=> $stable(sh_q));

  // R10: transmit-done holds until cleared
  a_r10_tx_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_done) |=> done_q);

endmodule

// File: rtl/mm_serial_rx.sv
module mm_serial_rx
  import mm_serial_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          long_frame,
  input  logic          rxd,
  input  logic          clr_done,
  input  logic          clr_fe,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          done,
  output logic          fe
);

  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DW + 3);
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] SC_A   = CW'(MID - 1);
  localparam logic [CW-1:0] SC_B   = CW'(MID);
  localparam logic [CW-1:0] SC_C   = CW'(MID + 1);
  localparam logic [CW-1:0] SC_END = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_S = BW'(DW + 1);
  localparam logic [BW-1:0] LAST_L = BW'(DW + 2);
  localparam logic [BW-1:0] DATA_HI = BW'(DW);

  logic          s1_q, rxs_q;
  logic          run_q, run_d;
  logic          f11_q, f11_d;
  logic [CW-1:0] sc_q, sc_d;
  logic [BW-1:0] bi_q, bi_d;
  logic [1:0]    vote_q, vote_d;
  logic [DW-1:0] dsh_q, dsh_d;
  logic          b9_q, b9_d;
  logic [DW-1:0] data_q, data_d;
  logic          rb9_q, rb9_d;
  logic          done_q, done_d, done_set;
  logic          fe_q, fe_d, fe_set;
  logic          bitv;
  logic [BW-1:0] last_idx;

  always_comb begin
    run_d    = run_q;
    f11_d    = f11_q;
    sc_d     = sc_q;
    bi_d     = bi_q;
    vote_d   = vote_q;
    dsh_d    = dsh_q;
    b9_d     = b9_q;
    data_d   = data_q;
    rb9_d    = rb9_q;
    done_set = 1'b0;
    fe_set   = 1'b0;
    bitv     = vote3(vote_q[1], vote_q[0], rxs_q);
    last_idx = f11_q ? LAST_L : LAST_S;
    if (!run_q) begin
      if (tick && !rxs_q) begin
        run_d = 1'b1;
        f11_d = long_frame;
        sc_d  = CW'(1);
        bi_d  = '0;
      end
    end else if (tick) begin
      if (sc_q == SC_END) begin
        sc_d = '0;
        bi_d = bi_q + 1'b1;
      end else begin
        sc_d = sc_q + 1'b1;
      end
      if (sc_q == SC_A || sc_q == SC_B) vote_d = {vote_q[0], rxs_q};
      if (sc_q == SC_C) begin
        if (bi_q == '0) begin
          if (bitv) run_d = 1'b0;
        end else if (bi_q == last_idx) begin
          run_d    = 1'b0;
          data_d   = dsh_q;
          rb9_d    = f11_q ? b9_q : bitv;
          done_set = 1'b1;
          fe_set   = !bitv;
        end else if (bi_q <= DATA_HI) begin
          dsh_d = {bitv, dsh_q[DW-1:1]};
        end else begin
          b9_d = bitv;
        end
      end
    end
    done_d = done_set ? 1'b1 : (clr_done ? 1'b0 : done_q);
    fe_d   = fe_set   ? 1'b1 : (clr_fe   ? 1'b0 : fe_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      rxs_q  <= 1'b1;
      run_q  <= 1'b0;
      f11_q  <= 1'b0;
      sc_q   <= '0;
      bi_q   <= '0;
      vote_q <= '0;
      dsh_q  <= '0;
      b9_q   <= 1'b0;
      data_q <= '0;
      rb9_q  <= 1'b0;
      done_q <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      s1_q   <= rxd;
      rxs_q  <= s1_q;
      run_q  <= run_d;
      f11_q  <= f11_d;
      sc_q   <= sc_d;
      bi_q   <= bi_d;
      vote_q <= vote_d;
      dsh_q  <= dsh_d;
      b9_q   <= b9_d;
      data_q <= data_d;
      rb9_q  <= rb9_d;
      done_q <= done_d;
      fe_q   <= fe_d;
    end
  end

  assign data = data_q;
  assign bit9 = rb9_q;
  assign done = done_q;
  assign fe   = fe_q;

  // R9: a start bit voted high drops back to idle with no completion
  a_r9_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && sc_q == SC_C && bi_q == '0 && bitv) |=>
      (!run_q && !$rose(done_q)));

  // R6: framing error is sticky until its clear
  a_r6_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && !clr_fe) |=> fe_q);

  // R10: receive-done holds until cleared
  a_r10_rx_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_done) |=> done_q);

endmodule

// File: rtl/mm_serial_port.sv
module mm_serial_port
  import mm_serial_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    frame_mode,
  input  logic          fix_slow,
  input  logic          fe_vis,
  input  logic          var_tick,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_bit9,
  input  logic          clr_tx_done,
  input  logic          clr_rx_done,
  input  logic          clr_fe,
  input  logic          rxd,
  output logic          txd,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          tx_done,
  output logic          rx_done,
  output logic          fe_flag,
  output logic          ctrl_top
);

  logic rst_m_q, rst_s_q;
  logic tick;
  logic long_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  assign long_frame = is_long(frame_mode);

  mm_serial_tick u_tick (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .frame_mode (frame_mode),
    .fix_slow   (fix_slow),
    .var_tick   (var_tick),
    .tick       (tick)
  );

  mm_serial_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .tick       (tick),
    .long_frame (long_frame),
    .wr         (tx_wr),
    .data       (tx_data),
    .bit9       (tx_bit9),
    .clr_done   (clr_tx_done),
    .txd        (txd),
    .done       (tx_done)
  );

  mm_serial_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .tick       (tick),
    .long_frame (long_frame),
    .rxd        (rxd),
    .clr_done   (clr_rx_done),
    .clr_fe     (clr_fe),
    .data       (rx_data),
    .bit9       (rx_bit9),
    .done       (rx_done),
    .fe         (fe_flag)
  );

  // R7: readback bit shows framing error or mode bit 0
  assign ctrl_top = fe_vis ? fe_flag : frame_mode[0];

endmodule

// File: tb/mm_serial_port_bench.sv
module mm_serial_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] frame_mode = 2'b10;
  logic       fix_slow = 1'b0;
  logic       fe_vis = 1'b0;
  logic       var_tick = 1'b0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_bit9 = 1'b0;
  logic       clr_tx_done = 1'b0;
  logic       clr_rx_done = 1'b0;
  logic       clr_fe = 1'b0;
  logic       loop_en = 1'b1;
  logic       line_q = 1'b1;
  logic       rxd;
  logic       txd;
  logic [7:0] rx_data;
  logic       rx_bit9, tx_done, rx_done, fe_flag, ctrl_top;
  int         n_total = 0;
  int         n_fail = 0;

  assign rxd = loop_en ? txd : line_q;

  always #2 clk = ~clk;

  mm_serial_port u_mm_serial_port (
    .clk(clk), .rst_n(rst_n), .frame_mode(frame_mode), .fix_slow(fix_slow),
    .fe_vis(fe_vis), .var_tick(var_tick), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_bit9(tx_bit9), .clr_tx_done(clr_tx_done), .clr_rx_done(clr_rx_done),
    .clr_fe(clr_fe), .rxd(rxd), .txd(txd), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .tx_done(tx_done), .rx_done(rx_done),
    .fe_flag(fe_flag), .ctrl_top(ctrl_top)
  );

  // variable-rate oversampling tick: one pulse every third clock
  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      c = (c == 2) ? 0 : c + 1;
      var_tick = (c == 0);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic b9);
    @(negedge clk);
    tx_data = d; tx_bit9 = b9; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic cap_tx(input int nb, input int per, output logic [10:0] bits);
    int cnt;
    cnt  = 0;
    bits = '1;
    for (int k = 0; k < nb; k++) begin
      while (cnt < per * k + per / 2) begin
        @(negedge clk);
        cnt++;
      end
      bits[k] = txd;
    end
  endtask

  task automatic wait_rx(input int lim, output logic ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (rx_done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic wait_tx(input int lim, output logic ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (tx_done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_tx_done = 1'b1; clr_rx_done = 1'b1; clr_fe = 1'b1;
    @(negedge clk);
    clr_tx_done = 1'b0; clr_rx_done = 1'b0; clr_fe = 1'b0;
  endtask

  task automatic drive_frame(input logic [10:0] bits, input int nb, input int per,
                             input logic [10:0] gmask);
    for (int k = 0; k < nb; k++) begin
      for (int c = 0; c < per; c++) begin
        @(negedge clk);
        line_q = bits[k] ^ (gmask[k] && c == per / 2);
      end
    end
    @(negedge clk);
    line_q = 1'b1;
    repeat (per) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 txd idle", txd, 1'b1);
    chk("R12 tx_done", tx_done, 1'b0);
    chk("R12 rx_done", rx_done, 1'b0);
    chk("R12 fe_flag", fe_flag, 1'b0);
    chk("R12 rx_data", {rx_bit9, rx_data}, 9'h000);
  endtask

  task automatic t_short_frame();
    logic [10:0] b;
    logic ok;
    frame_mode = 2'b01; loop_en = 1'b1;
    wr_byte(8'hA5, 1'b0);
    cap_tx(10, 48, b);
    chk("R1 R5 short frame bits on var_tick", b, {2'b11, 8'hA5, 1'b0});
    wait_rx(2000, ok);
    chk("R2 short frame received", {ok, rx_bit9, rx_data}, {2'b11, 8'hA5});
    wait_tx(2000, ok);
    chk("R10 tx_done after stop", ok, 1'b1);
    repeat (60) @(negedge clk);
    chk("R10 flags stay set", {tx_done, rx_done}, 2'b11);
    clear_all();
    chk("R10 flags cleared", {tx_done, rx_done}, 2'b00);
  endtask

  task automatic t_long_fixed(input logic [7:0] d, input logic b9, input logic slow);
    logic [10:0] b;
    logic ok;
    int per;
    per = slow ? 32 : 16;
    frame_mode = 2'b10; fix_slow = slow; loop_en = 1'b1;
    wr_byte(d, b9);
    cap_tx(11, per, b);
    chk(slow ? "R3 R5 long frame at 32 clocks" : "R3 R5 long frame at 16 clocks",
        b, {1'b1, b9, d, 1'b0});
    wait_rx(2000, ok);
    chk("R4 ninth bit received", {ok, rx_bit9, rx_data}, {1'b1, b9, d});
    wait_tx(2000, ok);
    clear_all();
    fix_slow = 1'b0;
  endtask

  task automatic t_long_var();
    logic [10:0] b;
    logic ok;
    frame_mode = 2'b11; loop_en = 1'b1;
    wr_byte(8'h5A, 1'b0);
    cap_tx(11, 48, b);
    chk("R5 mode 11 uses var_tick", b, {2'b10, 8'h5A, 1'b0});
    wait_rx(2000, ok);
    chk("R4 stop bit not kept in rx_bit9", {ok, rx_bit9, rx_data, fe_flag}, {2'b10, 8'h5A, 1'b0});
    wait_tx(2000, ok);
    clear_all();
  endtask

  task automatic t_framing();
    logic ok;
    loop_en = 1'b0; frame_mode = 2'b01;
    drive_frame({2'b00, 8'h81, 1'b0}, 10, 48, 11'h000);
    wait_rx(500, ok);
    chk("R6 low stop sets fe_flag", {ok, fe_flag}, 2'b11);
    chk("R2 short frame keeps stop value", {rx_bit9, rx_data}, {1'b0, 8'h81});
    frame_mode = 2'b10; fe_vis = 1'b0;
    @(negedge clk);
    chk("R7 ctrl_top shows mode bit 0", ctrl_top, 1'b0);
    fe_vis = 1'b1;
    @(negedge clk);
    chk("R7 ctrl_top shows framing error", ctrl_top, 1'b1);
    clr_rx_done = 1'b1;
    @(negedge clk);
    clr_rx_done = 1'b0;
    drive_frame({2'b11, 8'h3E, 1'b0}, 11, 16, 11'h000);
    wait_rx(500, ok);
    chk("R6 fe_flag survives good frame", {ok, fe_flag, rx_data}, {2'b11, 8'h3E});
    clear_all();
    chk("R6 R7 fe cleared", {fe_flag, ctrl_top}, 2'b00);
    frame_mode = 2'b11; fe_vis = 1'b0;
    @(negedge clk);
    chk("R7 ctrl_top follows mode bit 0", ctrl_top, 1'b1);
    frame_mode = 2'b10;
  endtask

  task automatic t_glitch();
    logic ok;
    loop_en = 1'b0; frame_mode = 2'b10;
    drive_frame({2'b10, 8'h20, 1'b0}, 11, 16, 11'b000_0101_0000);
    wait_rx(500, ok);
    chk("R8 one-sample glitch ignored", {ok, rx_bit9, rx_data, fe_flag}, {2'b10, 8'h20, 1'b0});
    clear_all();
  endtask

  task automatic t_false_start();
    logic ok;
    loop_en = 1'b0; frame_mode = 2'b10;
    @(negedge clk); line_q = 1'b0;
    repeat (5) @(negedge clk);
    line_q = 1'b1;
    repeat (200) @(negedge clk);
    chk("R9 false start gives no frame", {rx_done, fe_flag}, 2'b00);
    drive_frame({2'b11, 8'h4B, 1'b0}, 11, 16, 11'h000);
    wait_rx(500, ok);
    chk("R9 next frame accepted", {ok, rx_bit9, rx_data}, {2'b11, 8'h4B});
    clear_all();
  endtask

  task automatic t_busy_write();
    logic ok;
    int lows;
    loop_en = 1'b1; frame_mode = 2'b10;
    wr_byte(8'h11, 1'b0);
    repeat (40) @(negedge clk);
    wr_byte(8'hEE, 1'b1);
    wait_rx(500, ok);
    chk("R11 frame in flight unchanged", {ok, rx_bit9, rx_data}, {2'b10, 8'h11});
    wait_tx(500, ok);
    clear_all();
    lows = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk("R11 no second frame sent", {lows[7:0], rx_done, tx_done}, 10'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_short_frame();
    t_long_fixed(8'h3C, 1'b1, 1'b0);
    t_long_fixed(8'hC3, 1'b0, 1'b0);
    t_long_fixed(8'h96, 1'b0, 1'b1);
    t_long_var();
    t_framing();
    t_glitch();
    t_false_start();
    t_busy_write();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule